// File: doc/BRIEF.md
# Four-Phase Signal Head Sequencer

This block drives the red, amber and green lamps of a single signal head. It is a synchronous Moore machine that steps through four phases in a fixed loop: stop (red), prepare (red and amber together), go (green) and caution (amber alone). The phase is held as a dense two-bit code. The three lamp outputs are plain logic functions of those two bits, so no output register lies between the code and the lamps.

Each phase lasts a fixed number of clock cycles, and each phase has its own parameter for that count. A down-counter holds the number of cycles left in the current phase. When the counter expires, the machine steps to the next phase and the counter reloads in that same cycle. A synchronous, active-high reset returns the head to the stop phase with a fresh stop interval.

The block is meant to sit under a slow enable or a divided clock, so that the cycle counts map onto seconds.

Top module: `lamp_phase_seq`

## Requirements
- R1: The phase code on `phase_code` takes exactly four values: 2'b00 is stop, 2'b01 is prepare, 2'b10 is go and 2'b11 is caution. Phases always follow the loop 00 → 01 → 10 → 11 → 00.
- R2: When `rst` is high at a rising clock edge, `phase_code` becomes 2'b00 after that edge, whatever the earlier phase was. After `rst` drops, the stop phase lasts its full `RED_CYC` cycles, counted from the last reset edge.
- R3: The lamps for each phase are: stop lights red only, prepare lights red and amber, go lights green only, and caution lights amber only.
- R4: `lamp_red` equals the inverse of code bit 1, and `lamp_amber` equals code bit 0. `lamp_green` is high only for code 2'b10. Red and green are never high in the same cycle.
- R5: The stop, prepare, go and caution phases last exactly `RED_CYC`, `REDAMB_CYC`, `GRN_CYC` and `AMB_CYC` clock cycles. Each of these counts must be at least 1.
- R6: The phase never changes before its cycle count has run out, and it never stays longer than that count.
- R7: A phase whose count is 1 appears for exactly one cycle and is not skipped.
- R8: While `rst` stays high over several edges, the head stays in stop with only red lit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lamp_red | output | 1 | Red lamp drive |
| lamp_amber | output | 1 | Amber lamp drive |
| lamp_green | output | 1 | Green lamp drive |
| phase_code | output | 2 | Current phase code (see R1) |

## Verification
The bench measures how long each phase is visible at the ports and compares that with the four cycle-count parameters. An off-by-one in the counter load would show up as every phase running one cycle long or short. A one-cycle caution phase checks the case where the counter reloads to zero: a design that mishandles it would skip caution entirely or hold it for two cycles. A reset asserted in the middle of the go phase catches a counter that is not reloaded, which would make the first stop interval after reset too short. Every cycle, the lamps are compared with the decode of the phase code, so a wrong XOR in the next-state logic or a swapped lamp bit gives an out-of-order phase or a red-with-green cycle.

// File: rtl/lamp_seq_pkg.sv
package lamp_seq_pkg;

    // Two-bit phase code; the numeric values are the loop order
    typedef enum logic [1:0] {
        PH_STOP    = 2'b00,
        PH_PREPARE = 2'b01,
        PH_GO      = 2'b10,
        PH_CAUTION = 2'b11
    } phase_e;

endpackage

// File: rtl/lamp_seq_step.sv
module lamp_seq_step
    import lamp_seq_pkg::*;
(
    input  phase_e cur_ph,
    output phase_e nxt_ph
);
    logic [1:0] cur_bits;
    logic [1:0] nxt_bits;

    always_comb begin
        cur_bits    = cur_ph;
        // low bit toggles on every step, high bit takes the XOR of both
        nxt_bits[0] = ~cur_bits[0];
        nxt_bits[1] = cur_bits[1] ^ cur_bits[0];
        nxt_ph      = phase_e'(nxt_bits);
    end
endmodule

// File: rtl/lamp_seq_dwell_sel.sv
module lamp_seq_dwell_sel
    import lamp_seq_pkg::*;
#(
    parameter int RED_CYC    = 30,
    parameter int REDAMB_CYC = 3,
    parameter int GRN_CYC    = 25,
    parameter int AMB_CYC    = 4,
    parameter int CW         = 5
) (
    input  phase_e          ph,
    output logic [CW-1:0]   load_val
);
    // Counter value on phase entry is (duration - 1)
    always_comb begin
        unique case (ph)
            PH_STOP:    load_val = CW'(RED_CYC - 1);
            PH_PREPARE: load_val = CW'(REDAMB_CYC - 1);
            PH_GO:      load_val = CW'(GRN_CYC - 1);
            default:    load_val = CW'(AMB_CYC - 1);
        endcase
    end
endmodule

// File: rtl/lamp_seq_decode.sv
module lamp_seq_decode
    import lamp_seq_pkg::*;
(
    input  phase_e ph,
    output logic   red_on,
    output logic   amber_on,
    output logic   green_on
);
    logic [1:0] b;

    always_comb begin
        b        = ph;
        red_on   = ~b[1];
        amber_on = b[0];
        green_on = b[1] & ~b[0];
    end
endmodule

// File: rtl/lamp_phase_seq.sv
module lamp_phase_seq
    import lamp_seq_pkg::*;
#(
    parameter int RED_CYC    = 30,
    parameter int REDAMB_CYC = 3,
    parameter int GRN_CYC    = 25,
    parameter int AMB_CYC    = 4
) (
    input  logic       clk,
    input  logic       rst,
    output logic       lamp_red,
    output logic       lamp_amber,
    output logic       lamp_green,
    output logic [1:0] phase_code
);
    localparam int MAX_AB  = (RED_CYC > REDAMB_CYC) ? RED_CYC : REDAMB_CYC;
    localparam int MAX_CD  = (GRN_CYC > AMB_CYC) ? GRN_CYC : AMB_CYC;
    localparam int MAX_DUR = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CW      = (MAX_DUR > 1) ? $clog2(MAX_DUR) : 1;

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] left;
    } seq_state_t;

    seq_state_t st_d, st_q;
    phase_e        step_ph;
    logic [CW-1:0] step_load;
    logic [CW-1:0] stop_load;

    lamp_seq_step u_step (
        .cur_ph (st_q.ph),
        .nxt_ph (step_ph)
    );

    // reload value for the phase being entered
    lamp_seq_dwell_sel #(
        .RED_CYC(RED_CYC), .REDAMB_CYC(REDAMB_CYC),
        .GRN_CYC(GRN_CYC), .AMB_CYC(AMB_CYC), .CW(CW)
    ) u_sel_next (
        .ph       (step_ph),
        .load_val (step_load)
    );

    // reload value used by reset
    lamp_seq_dwell_sel #(
        .RED_CYC(RED_CYC), .REDAMB_CYC(REDAMB_CYC),
        .GRN_CYC(GRN_CYC), .AMB_CYC(AMB_CYC), .CW(CW)
    ) u_sel_stop (
        .ph       (PH_STOP),
        .load_val (stop_load)
    );

    lamp_seq_decode u_dec (
        .ph       (st_q.ph),
        .red_on   (lamp_red),
        .amber_on (lamp_amber),
        .green_on (lamp_green)
    );

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.ph   = PH_STOP;
            st_d.left = stop_load;
        end else if (st_q.left == '0) begin
            st_d.ph   = step_ph;
            st_d.left = step_load;
        end else begin
            st_d.left = st_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign phase_code = st_q.ph;
endmodule

// File: rtl/lamp_seq_chk.sv
module lamp_seq_chk #(
    parameter int RED_CYC    = 30,
    parameter int REDAMB_CYC = 3,
    parameter int GRN_CYC    = 25,
    parameter int AMB_CYC    = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       lamp_red,
    input logic       lamp_amber,
    input logic       lamp_green,
    input logic [1:0] phase_code
);
    function automatic int dur_of(input logic [1:0] c);
        case (c)
            2'b00:   return RED_CYC;
            2'b01:   return REDAMB_CYC;
            2'b10:   return GRN_CYC;
            default: return AMB_CYC;
        endcase
    endfunction

    // held_q: cycles of the current phase seen before the present one
    logic [31:0] held_q;
    logic [1:0]  last_q;
    logic        fresh_q;

    always_ff @(posedge clk) begin
        last_q <= phase_code;
        if (rst) begin
            held_q  <= 32'd0;
            fresh_q <= 1'b1;
        end else begin
            fresh_q <= 1'b0;
            if (fresh_q || phase_code == last_q) held_q <= held_q + 32'd1;
            else                                 held_q <= 32'd1;
        end
    end

    assert_reset_stop_R2: assert property (@(posedge clk)
        rst |=> (phase_code == 2'b00));

    assert_phase_order_R1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($stable(phase_code) || phase_code == $past(phase_code) + 2'd1));

    assert_one_phase_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot({lamp_red & ~lamp_amber, lamp_red & lamp_amber,
                 lamp_green, lamp_amber & ~lamp_red}));

    assert_no_red_green_R4: assert property (@(posedge clk) disable iff (rst)
        !(lamp_red && lamp_green));

    assert_prepare_lamps_R3: assert property (@(posedge clk) disable iff (rst)
        (phase_code == 2'b01) |-> (lamp_red && lamp_amber && !lamp_green));

    assert_caution_lamps_R3: assert property (@(posedge clk) disable iff (rst)
        (phase_code == 2'b11) |-> (!lamp_red && lamp_amber && !lamp_green));

    assert_exact_dwell_R5: assert property (@(posedge clk) disable iff (rst)
        (!fresh_q && phase_code != last_q) |-> (held_q == 32'(dur_of(last_q))));

    assert_no_overstay_R6: assert property (@(posedge clk) disable iff (rst)
        (!fresh_q && phase_code == last_q) |-> (held_q < 32'(dur_of(phase_code))));
endmodule

bind lamp_phase_seq lamp_seq_chk #(
    .RED_CYC(RED_CYC), .REDAMB_CYC(REDAMB_CYC),
    .GRN_CYC(GRN_CYC), .AMB_CYC(AMB_CYC)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .lamp_red   (lamp_red),
    .lamp_amber (lamp_amber),
    .lamp_green (lamp_green),
    .phase_code (phase_code)
);

// File: tb/lamp_phase_seq_tb.sv
module lamp_phase_seq_tb;
    localparam int T_RED = 3;
    localparam int T_RA  = 2;
    localparam int T_GRN = 4;
    localparam int T_AMB = 1;
    localparam int LOOP  = T_RED + T_RA + T_GRN + T_AMB;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       lamp_red, lamp_amber, lamp_green;
    logic [1:0] phase_code;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // requirement-level model: phase and cycles left including current one
    logic [1:0] m_ph;
    int         m_left;

    always #10 clk = ~clk;

    lamp_phase_seq #(
        .RED_CYC(T_RED), .REDAMB_CYC(T_RA), .GRN_CYC(T_GRN), .AMB_CYC(T_AMB)
    ) u_dut (
        .clk(clk), .rst(rst),
        .lamp_red(lamp_red), .lamp_amber(lamp_amber), .lamp_green(lamp_green),
        .phase_code(phase_code)
    );

    function automatic int dur(input logic [1:0] c);
        case (c)
            2'b00:   return T_RED;
            2'b01:   return T_RA;
            2'b10:   return T_GRN;
            default: return T_AMB;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_outputs(input string req);
        logic [2:0] exp_l;
        case (m_ph)
            2'b00:   exp_l = 3'b100;
            2'b01:   exp_l = 3'b110;
            2'b10:   exp_l = 3'b001;
            default: exp_l = 3'b010;
        endcase
        check(phase_code == m_ph, req, "phase_code", int'(phase_code), int'(m_ph));
        check({lamp_red, lamp_amber, lamp_green} == exp_l, req, "lamps {r,a,g}",
              int'({lamp_red, lamp_amber, lamp_green}), int'(exp_l));
        check(!(lamp_red && lamp_green), "R4", "red+green", 1, 0);
    endtask

    // one clock: model follows the edge, then outputs are compared
    task automatic tick(input string req);
        @(posedge clk);
        if (rst) begin
            m_ph   = 2'b00;
            m_left = T_RED;
        end else if (m_left == 1) begin
            m_ph   = m_ph + 2'd1;
            m_left = dur(m_ph);
        end else begin
            m_left = m_left - 1;
        end
        @(negedge clk);
        check_outputs(req);
    endtask

    task automatic t_reset_hold();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 4; i++) tick("R8");
        check(phase_code == 2'b00 && lamp_red && !lamp_amber && !lamp_green,
              "R2", "reset stop", int'(phase_code), 0);
        rst = 1'b0;
    endtask

    task automatic t_loops();
        for (int i = 0; i < 2 * LOOP; i++) tick("R1");
    endtask

    // measure visible run lengths from the ports only
    task automatic t_durations();
        logic [1:0] seen;
        int run;
        // align to the first cycle of a stop phase
        while (!(phase_code == 2'b00 && m_left == T_RED)) tick("R5");
        seen = phase_code;
        run  = 1;
        for (int i = 0; i < LOOP; i++) begin
            tick("R5");
            if (phase_code == seen) begin
                run++;
            end else begin
                check(run == dur(seen), seen == 2'b11 ? "R7" : "R5",
                      "phase length", run, dur(seen));
                check(phase_code == seen + 2'd1, "R1", "next phase",
                      int'(phase_code), int'(seen + 2'd1));
                seen = phase_code;
                run  = 1;
            end
        end
    endtask

    task automatic t_mid_reset();
        int run;
        while (phase_code != 2'b10) tick("R6");
        tick("R6");
        rst = 1'b1;
        tick("R2");
        rst = 1'b0;
        // the reset edge is the first stop cycle; count the remaining ones
        run = 1;
        while (phase_code == 2'b00 && run < 10) begin
            tick("R2");
            if (phase_code == 2'b00) run++;
        end
        check(run == T_RED, "R2", "stop length after reset", run, T_RED);
        check(phase_code == 2'b01, "R1", "phase after stop", int'(phase_code), 1);
    endtask

    initial begin
        m_ph   = 2'b00;
        m_left = T_RED;
        t_reset_hold();
        t_loops();
        t_durations();
        t_mid_reset();
        t_loops();
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule